// File: doc/BRIEF.md
# Residue-3 Self-Checking Arithmetic Unit

This block performs a 32-bit addition or a 32×32 multiplication and checks every result against a modulo-3 residue path that runs beside the main datapath. The residue of each operand is formed from its 2-bit groups, which works because 4 ≡ 1 (mod 3). The two operand residues are combined by the same operation, modulo 3, and the outcome is compared with the residue of the produced result. A mismatch raises the error flag in the same cycle that the result is presented. The fault behind it may be permanent (a mask held across many operations) or transient (a mask applied to one operation only).

A request is accepted on a rising clock edge with `in_valid_i` high. The operands and the operation select are captured, and the result appears, together with `res_valid_o` and `err_o`, right after that edge. A two-state sequencer tracks whether the captured result is being presented.

- **ST_IDLE**: no result is presented.
- **ST_EMIT**: the result of the request captured at the last edge is on the outputs.

The sequencer has four transitions:

- **ACCEPT**: ST_IDLE to ST_EMIT when `in_valid_i` is high.
- **STREAM**: ST_EMIT stays in ST_EMIT when `in_valid_i` is high.
- **DRAIN**: ST_EMIT to ST_IDLE when `in_valid_i` is low.
- **WAIT**: ST_IDLE stays in ST_IDLE when `in_valid_i` is low.

For test, stuck-at-0 and stuck-at-1 bit masks can be forced onto the datapath's copy of each operand and onto the result path. The residue checker always works from the clean captured operands, so the masks model faults inside the arithmetic hardware.

Top module: `sc3_arith_unit`

## Requirements
- R1: While `rst_n` is low and after its release, before any request, `res_valid_o` and `err_o` are 0.
- R2: A request sampled with `in_valid_i`=1 at a rising edge is presented right after that edge: `res_valid_o`=1 for one cycle per request. Back-to-back requests give an unbroken run of valid cycles, with results in request order.
- R3: With `op_i`=0 (add), `res_o[31:0]` is the 32-bit sum and `res_o[32]` is the carry-out. When no result mask is set, `res_o[63:33]` is 0.
- R4: With `op_i`=1 (multiply), `res_o[63:0]` is the full unsigned 64-bit product.
- R5: With every fault mask at zero, `err_o` stays 0 for all operands and both operations.
- R6: `err_o` is 1 exactly when the residue mod 3 of the presented 64-bit result differs from the mod-3 combination of the clean operand residues. The combination is (ra+rb) mod 3 for add and (ra·rb) mod 3 for multiply. A result-path stuck-at that changes a single bit is always flagged. A stuck-at whose bit already holds the forced value changes nothing and raises no error.
- R7: In add, a fault that changes one bit of either datapath operand is always flagged.
- R8: In multiply, a fault that changes one bit of operand A is flagged when B mod 3 ≠ 0. It goes undetected (`err_o`=0, wrong product delivered) when B mod 3 = 0.
- R9: Each mask bit set to 1 forces its bit: the sa0 mask forces 0 and the sa1 mask forces 1. Where both are set, the bit reads 1. Masks act only on the datapath copies, never on the residue checker's inputs.
- R10: `err_o` is asserted only together with `res_valid_o`, in the cycle that presents the faulty result.
- R11: With `in_valid_i` low at an edge, the sequencer takes DRAIN or WAIT, and `res_valid_o` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request strobe |
| op_i | input | 1 | Operation: 0 add, 1 multiply |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| fa_sa0_i | input | 32 | Stuck-at-0 mask on datapath operand A |
| fa_sa1_i | input | 32 | Stuck-at-1 mask on datapath operand A |
| fb_sa0_i | input | 32 | Stuck-at-0 mask on datapath operand B |
| fb_sa1_i | input | 32 | Stuck-at-1 mask on datapath operand B |
| fr_sa0_i | input | 64 | Stuck-at-0 mask on the result path |
| fr_sa1_i | input | 64 | Stuck-at-1 mask on the result path |
| res_o | output | 64 | Result: sum with carry in bit 32, or full product |
| err_o | output | 1 | Residue mismatch flag |
| res_valid_o | output | 1 | Result presented this cycle |

## Verification
The bench targets three corner cases of the checker.

- **Multiply blind spot.** A flipped bit of operand A is paired once with a B that is a multiple of 3 and once with a B that is not. A checker that drew its residues from the faulted operands would miss both flips. One that ignored the blind spot would flag both.
- **Add carry-out.** Sums that overflow 32 bits are checked. An add check that dropped the carry-out from the result residue would raise false errors on these.
- **Masks that change nothing.** Stuck-at masks that match the bit already present, and sa0/sa1 overlaps, are checked. A design with the wrong mask priority, or one that flagged the mere presence of a mask, would show a wrong result or a spurious error.

Streams of back-to-back requests with gaps between them test ordering and the drop of `res_valid_o` after a gap.

// File: rtl/sc3_pkg.sv
package sc3_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_MUL = 1'b1
    } arith_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } seq_state_e;

    // Reduce a small nonnegative value to its residue mod 3 by repeatedly
    // summing its 2-bit groups (each group has weight 4^k == 1 mod 3).
    function automatic logic [1:0] fold_mod3(input logic [15:0] v);
        logic [15:0] t;
        logic [15:0] s;
        t = v;
        for (int it = 0; it < 4; it++) begin
            s = '0;
            for (int k = 0; k < 8; k++) begin
                s = s + 16'(t[2*k +: 2]);
            end
            t = s;
        end
        return (t[1:0] == 2'd3) ? 2'd0 : t[1:0];
    endfunction

    function automatic logic [1:0] add_mod3(input logic [1:0] x, input logic [1:0] y);
        logic [2:0] s;
        s = {1'b0, x} + {1'b0, y};
        return (s >= 3'd3) ? 2'(s - 3'd3) : s[1:0];
    endfunction

    function automatic logic [1:0] mul_mod3(input logic [1:0] x, input logic [1:0] y);
        logic [3:0] p;
        p = {2'b00, x} * {2'b00, y};
        // Residues are 0..2, so the product is one of 0, 1, 2 or 4.
        return (p == 4'd4) ? 2'd1 : p[1:0];
    endfunction

endpackage

// File: rtl/mod3_residue.sv
module mod3_residue #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    output logic [1:0]   r_o
);
    localparam int NP = (W + 1) / 2;
    localparam int SW = $clog2(3 * NP + 1);

    logic [2*NP-1:0] padded;
    logic [1:0]      pair [NP];
    logic [SW-1:0]   pair_sum;

    assign padded = (2*NP)'(x_i);

    for (genvar k = 0; k < NP; k++) begin : g_pair
        assign pair[k] = padded[2*k +: 2];
    end

    always_comb begin
        pair_sum = '0;
        for (int k = 0; k < NP; k++) begin
            pair_sum = pair_sum + SW'(pair[k]);
        end
    end

    assign r_o = sc3_pkg::fold_mod3(16'(pair_sum));

endmodule

// File: rtl/sc3_datapath.sv
module sc3_datapath
    import sc3_pkg::*;
#(
    parameter int W = 32
) (
    input  arith_op_e        op_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic [W-1:0]     fa_sa0_i,
    input  logic [W-1:0]     fa_sa1_i,
    input  logic [W-1:0]     fb_sa0_i,
    input  logic [W-1:0]     fb_sa1_i,
    input  logic [2*W-1:0]   fr_sa0_i,
    input  logic [2*W-1:0]   fr_sa1_i,
    output logic [2*W-1:0]   res_o
);
    localparam int RW = 2 * W;

    logic [W-1:0]  a_dp;
    logic [W-1:0]  b_dp;
    logic [W:0]    sum_w;
    logic [RW-1:0] prod_w;
    logic [RW-1:0] raw_w;

    // Stuck-at-1 overrides stuck-at-0 where both are set.
    assign a_dp   = (a_i & ~fa_sa0_i) | fa_sa1_i;
    assign b_dp   = (b_i & ~fb_sa0_i) | fb_sa1_i;

    assign sum_w  = {1'b0, a_dp} + {1'b0, b_dp};
    assign prod_w = {{W{1'b0}}, a_dp} * {{W{1'b0}}, b_dp};

    always_comb begin
        unique case (op_i)
            OP_ADD: raw_w = {{(W-1){1'b0}}, sum_w};
            OP_MUL: raw_w = prod_w;
        endcase
    end

    assign res_o = (raw_w & ~fr_sa0_i) | fr_sa1_i;

endmodule

// File: rtl/sc3_residue_check.sv
module sc3_residue_check
    import sc3_pkg::*;
#(
    parameter int W = 32
) (
    input  arith_op_e      op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [2*W-1:0] res_i,
    output logic           mismatch_o
);
    logic [1:0] ra;
    logic [1:0] rb;
    logic [1:0] rr;
    logic [1:0] r_pred;

    mod3_residue #(.W(W))   u_res_a (.x_i(a_i),   .r_o(ra));
    mod3_residue #(.W(W))   u_res_b (.x_i(b_i),   .r_o(rb));
    mod3_residue #(.W(2*W)) u_res_r (.x_i(res_i), .r_o(rr));

    always_comb begin
        unique case (op_i)
            OP_ADD: r_pred = add_mod3(ra, rb);
            OP_MUL: r_pred = mul_mod3(ra, rb);
        endcase
    end

    assign mismatch_o = (r_pred != rr);

endmodule

// File: rtl/sc3_arith_unit.sv
module sc3_arith_unit
    import sc3_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic             op_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic [W-1:0]     fa_sa0_i,
    input  logic [W-1:0]     fa_sa1_i,
    input  logic [W-1:0]     fb_sa0_i,
    input  logic [W-1:0]     fb_sa1_i,
    input  logic [2*W-1:0]   fr_sa0_i,
    input  logic [2*W-1:0]   fr_sa1_i,
    output logic [2*W-1:0]   res_o,
    output logic             err_o,
    output logic             res_valid_o
);
    localparam int RW = 2 * W;

    seq_state_e  state_q;
    seq_state_e  state_d;
    arith_op_e   op_q;
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic [RW-1:0] dp_res;
    logic          mismatch;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: ACCEPT, STREAM, DRAIN, WAIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid_i ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid_i ? ST_EMIT : ST_IDLE;
        endcase
    end

    // Operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_ADD;
            a_q  <= '0;
            b_q  <= '0;
        end else if (in_valid_i) begin
            op_q <= arith_op_e'(op_i);
            a_q  <= a_i;
            b_q  <= b_i;
        end
    end

    sc3_datapath #(.W(W)) u_dp (
        .op_i     (op_q),
        .a_i      (a_q),
        .b_i      (b_q),
        .fa_sa0_i (fa_sa0_i),
        .fa_sa1_i (fa_sa1_i),
        .fb_sa0_i (fb_sa0_i),
        .fb_sa1_i (fb_sa1_i),
        .fr_sa0_i (fr_sa0_i),
        .fr_sa1_i (fr_sa1_i),
        .res_o    (dp_res)
    );

    // The checker sees the clean captured operands, never the masked copies.
    sc3_residue_check #(.W(W)) u_chk (
        .op_i       (op_q),
        .a_i        (a_q),
        .b_i        (b_q),
        .res_i      (dp_res),
        .mismatch_o (mismatch)
    );

    // Outputs
    always_comb begin
        res_o       = dp_res;
        res_valid_o = 1'b0;
        err_o       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                res_valid_o = 1'b0;
                err_o       = 1'b0;
            end
            ST_EMIT: begin
                res_valid_o = 1'b1;
                err_o       = mismatch;
            end
        endcase
    end

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> res_valid_o);

    p_valid_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !res_valid_o);

    p_err_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> !err_o);

    p_clean_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && ((fa_sa0_i | fa_sa1_i | fb_sa0_i | fb_sa1_i) == '0)
                     && ((fr_sa0_i | fr_sa1_i) == '0)) |-> !err_o);

    p_add_high_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && op_q == OP_ADD && ((fr_sa0_i | fr_sa1_i) == '0))
            |-> (res_o[RW-1:W+1] == '0));

    p_mul_blind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && op_q == OP_MUL && (b_q % 3) == 0
                     && ((fb_sa0_i | fb_sa1_i) == '0)
                     && ((fr_sa0_i | fr_sa1_i) == '0)) |-> !err_o);

endmodule

// File: tb/tb_sc3_arith_unit.sv
`timescale 1ns/1ps
module tb_sc3_arith_unit;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid_i = 1'b0;
    logic          op_i = 1'b0;
    logic [31:0]   a_i = '0, b_i = '0;
    logic [31:0]   fa_sa0_i = '0, fa_sa1_i = '0, fb_sa0_i = '0, fb_sa1_i = '0;
    logic [63:0]   fr_sa0_i = '0, fr_sa1_i = '0;
    logic [63:0]   res_o;
    logic          err_o;
    logic          res_valid_o;

    always #2 clk = ~clk;

    sc3_arith_unit #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i),
        .fa_sa0_i(fa_sa0_i), .fa_sa1_i(fa_sa1_i),
        .fb_sa0_i(fb_sa0_i), .fb_sa1_i(fb_sa1_i),
        .fr_sa0_i(fr_sa0_i), .fr_sa1_i(fr_sa1_i),
        .res_o(res_o), .err_o(err_o), .res_valid_o(res_valid_o)
    );

    typedef struct {
        logic [63:0] res;
        logic        err;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: present one request and push its expected outcome.
    task automatic send(input logic op, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] asa0, input logic [31:0] asa1,
                        input logic [31:0] bsa0, input logic [31:0] bsa1,
                        input logic [63:0] rsa0, input logic [63:0] rsa1,
                        input string tag);
        logic [31:0] af, bf;
        logic [63:0] raw, rf;
        logic [63:0] ra, rb, pred;
        exp_t e;
        @(negedge clk);
        in_valid_i = 1'b1; op_i = op; a_i = a; b_i = b;
        fa_sa0_i = asa0; fa_sa1_i = asa1; fb_sa0_i = bsa0; fb_sa1_i = bsa1;
        fr_sa0_i = rsa0; fr_sa1_i = rsa1;
        af  = (a & ~asa0) | asa1;
        bf  = (b & ~bsa0) | bsa1;
        raw = op ? ({32'b0, af} * {32'b0, bf}) : ({32'b0, af} + {32'b0, bf});
        rf  = (raw & ~rsa0) | rsa1;
        ra  = {32'b0, a} % 3;
        rb  = {32'b0, b} % 3;
        pred = op ? ((ra * rb) % 3) : ((ra + rb) % 3);
        e.res = rf;
        e.err = ((rf % 3) != pred);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid_i = 1'b0;
            fa_sa0_i = '0; fa_sa1_i = '0; fb_sa0_i = '0; fb_sa1_i = '0;
            fr_sa0_i = '0; fr_sa1_i = '0;
        end
    endtask

    task automatic clean(input logic op, input logic [31:0] a, input logic [31:0] b, input string tag);
        send(op, a, b, '0, '0, '0, '0, '0, '0, tag);
    endtask

    // Monitor: pop and compare just after each capturing edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && res_valid_o) begin
            if (q.size() == 0) begin
                check(1'b0, "R2 unexpected result", {63'b0, res_valid_o}, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(res_o === e.res, {e.tag, " result"}, res_o, e.res);
                check(err_o === e.err, {e.tag, " err"}, {63'b0, err_o}, {63'b0, e.err});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] x, y;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(res_valid_o === 1'b0, "R1 valid in reset", {63'b0, res_valid_o}, 64'd0);
        check(err_o === 1'b0, "R1 err in reset", {63'b0, err_o}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(res_valid_o === 1'b0, "R1 valid after reset", {63'b0, res_valid_o}, 64'd0);

        // R3 / R4 / R5: clean operations, including carry-out
        clean(1'b0, 32'd5, 32'd7, "R3 add small");
        clean(1'b0, 32'hFFFF_FFFF, 32'h0000_0001, "R3 add carry");
        clean(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 add max");
        clean(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 mul max");
        clean(1'b1, 32'd0, 32'h1234_5678, "R4 mul zero");
        clean(1'b1, 32'h0001_0000, 32'h0001_0000, "R4 mul shift");
        x = 32'h1357_9BDF; y = 32'h2468_ACE0;
        for (int i = 0; i < 40; i++) begin
            x = x * 32'd1664525 + 32'd1013904223;
            y = y * 32'd22695477 + 32'd1;
            clean(1'(i), x, y, "R5 clean stream");
        end
        idle(2);
        // R11: after a gap, nothing is presented
        @(negedge clk);
        check(res_valid_o === 1'b0, "R11 valid after gap", {63'b0, res_valid_o}, 64'd0);
        check(err_o === 1'b0, "R10 err without valid", {63'b0, err_o}, 64'd0);

        // R6: result-path faults
        send(1'b0, 32'd10, 32'd20, '0, '0, '0, '0, '0, 64'h1, "R6 res sa1 flips");
        send(1'b0, 32'd10, 32'd20, '0, '0, '0, '0, '0, 64'h2, "R6 res sa1 no change");
        send(1'b1, 32'd12345, 32'd678, '0, '0, '0, '0, 64'h1 << 40, '0, "R6 res sa0 no change");
        send(1'b1, 32'hFFFF_0000, 32'h0000_FFFF, '0, '0, '0, '0, '0, 64'h1 << 63, "R6 res sa1 top");

        // R7: add operand faults always flagged
        send(1'b0, 32'h10, 32'd9, '0, 32'h1, '0, '0, '0, '0, "R7 add a flip");
        send(1'b0, 32'd9, 32'hF0, '0, '0, 32'h10, '0, '0, '0, "R7 add b flip");

        // R8: multiply blind spot
        send(1'b1, 32'h10, 32'd9, '0, 32'h1, '0, '0, '0, '0, "R8 mul blind b%3=0");
        send(1'b1, 32'h10, 32'd7, '0, 32'h1, '0, '0, '0, '0, "R8 mul seen b%3=1");
        send(1'b1, 32'h10, 32'd11, '0, 32'h1, '0, '0, '0, '0, "R8 mul seen b%3=2");

        // R9: mask priority and masks that change nothing
        send(1'b0, 32'h0, 32'h0, 32'h4, 32'h4, '0, '0, '0, '0, "R9 overlap sa1 wins");
        send(1'b0, 32'h8, 32'h1, 32'h2, '0, '0, '0, '0, '0, "R9 sa0 on zero bit");
        idle(1);

        // R2: back-to-back permanent fault then transient recovery
        for (int i = 0; i < 6; i++)
            send(1'b1, 32'd100 + 32'(i), 32'd5, '0, '0, '0, '0, '0, 64'h4, "R2 stream perm");
        clean(1'b1, 32'd100, 32'd5, "R2 stream clear");
        idle(3);
        wait (q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule